// File: doc/BRIEF.md
# Protected Address Zone Access Gate

This block decides, for each host read or write command, whether the command may proceed. Four address windows can each be given an access mode: open for reading and writing, read-only, or hidden (no access at all). A command names its type, a starting sector address and a sector count. The block compares the whole sector range against every window. It returns one verdict per command: allow or abort.

Every window's settings are guarded by a per-window key. A configuration client must first present the matching key to unlock a window. While the window is unlocked, the client may move its bounds, change its mode or replace its key, and then lock it again. A wrong key leaves the window locked and raises a sticky error flag. A single shared input pin serves either as a global write-protect line or as a power-down request. A configuration operation selects which of the two it is, and write protect is the function after reset.

Commands enter on a valid/ready stream and verdicts leave on a second valid/ready stream. There is one verdict register between the two streams. A new command is accepted only when that register is empty, or when its verdict is being taken in the same cycle. A verdict that is held back by the consumer stays unchanged. Configuration is a plain write strobe with no back-pressure.

Top module: `zone_guard`

## Requirements
- R1: After reset the following hold. Every window is empty (base all ones, limit zero) and in mode read/write, with key zero, and locked. The shared pin acts as write protect. The error flag is 0, no verdict is pending, and `req_ready` is 1.
- R2: The mode field is `cfg_wdata[1:0]`, coded as 2'b00 read/write, 2'b01 read-only and 2'b10 hidden. The code 2'b11 behaves as hidden.
- R3: The unlock operation (op 0) unlocks the selected window only when `cfg_wdata` equals that window's stored key. A matching unlock clears `pw_err`. A mismatching unlock leaves the window locked and sets `pw_err`.
- R4: The set base (op 2), set limit (op 3), set mode (op 4) and set key (op 5) operations on a locked window have no effect.
- R5: A command of either type whose range overlaps a hidden window is aborted.
- R6: A write whose range overlaps a read-only window is aborted. A read over the same range is allowed.
- R7: A command covers sectors `req_lba` through `req_lba + count - 1`, and a count of 0 is treated as one sector. Window bounds are inclusive, and a window with limit below base covers nothing. A command that overlaps a restricted window by any number of sectors is aborted in full. A command that ends just before a window, or starts just after it, is allowed.
- R8: While the pin acts as write protect and `wppd_in` is 1, every write is aborted whatever the window modes. Reads are unaffected.
- R9: Op 6 selects the pin function from `cfg_wdata[0]`: 0 for write protect, 1 for power-down. In the power-down function the pin does not block writes, and `pd_req` equals `wppd_in`. In the write-protect function `pd_req` is 0.
- R10: A command accepted at a clock edge has its verdict on `rsp_valid` right after that edge. While `rsp_ready` is 0 the verdict holds and `req_ready` is 0.
- R11: While `rsp_valid` is 1, exactly one of `rsp_allow` and `rsp_abort` is 1. While `rsp_valid` is 0, both are 0.
- R12: The lock operation (op 1) relocks the selected window, after which R4 applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration operation strobe |
| cfg_op | input | 3 | Operation: 0 unlock, 1 lock, 2 base, 3 limit, 4 mode, 5 key, 6 pin function |
| cfg_zone | input | ZSEL_W (2) | Window selected by the operation |
| cfg_wdata | input | ADDR_W (32) | Key, bound, mode or pin function operand |
| pw_err | output | 1 | Sticky flag: last unlock attempt failed |
| wppd_in | input | 1 | Shared write-protect / power-down pin |
| pd_req | output | 1 | Power-down request when the pin has that function |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command accepted this cycle when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_lba | input | ADDR_W (32) | First sector of the command |
| req_count | input | CNT_W (16) | Sector count, 0 taken as 1 |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_allow | output | 1 | Command may proceed |
| rsp_abort | output | 1 | Command must be aborted |

## Verification
A corrupted mode, bound or lock bit shows as a wrong verdict. It appears on the first command that touches the affected window, one cycle after that command is accepted. For this reason the bench aims commands at the sectors just inside and just outside every bound. A wrong unlock or key register shows at once on `pw_err`, and also when a later mode change either takes effect or fails to. A verdict register that drops or changes its value during back-pressure shows on the next negative edge, and a command lost or duplicated between the streams leaves the verdict count out of step with the expected queue.

// File: rtl/zone_guard_pkg.sv
package zone_guard_pkg;

  typedef enum logic [1:0] {
    ZM_RW     = 2'b00,
    ZM_RO     = 2'b01,
    ZM_HIDDEN = 2'b10,
    ZM_RSVD   = 2'b11
  } zone_mode_e;

  typedef enum logic [2:0] {
    OP_UNLOCK = 3'd0,
    OP_LOCK   = 3'd1,
    OP_BASE   = 3'd2,
    OP_LIMIT  = 3'd3,
    OP_MODE   = 3'd4,
    OP_KEY    = 3'd5,
    OP_PINFN  = 3'd6,
    OP_NONE   = 3'd7
  } cfg_op_e;

endpackage

// File: rtl/zone_cfg_regs.sv
module zone_cfg_regs
  import zone_guard_pkg::*;
#(
  parameter int NZONE  = 4,
  parameter int ADDR_W = 32,
  parameter int ZSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [2:0]        cfg_op,
  input  logic [ZSEL_W-1:0] cfg_zone,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_o   [NZONE],
  output logic [ADDR_W-1:0] limit_o  [NZONE],
  output zone_mode_e        mode_o   [NZONE],
  output logic [NZONE-1:0]  unlocked_o,
  output logic              pin_pd_o,
  output logic              pw_err_o
);

  logic [ADDR_W-1:0] key_q [NZONE];
  logic              zone_ok;
  logic              key_hit;
  cfg_op_e           op;

  assign op      = cfg_op_e'(cfg_op);
  assign zone_ok = (int'(cfg_zone) < NZONE);
  assign key_hit = zone_ok && (cfg_wdata == key_q[cfg_zone]);

  // per-window settings, one update path per window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int z = 0; z < NZONE; z++) begin
        base_o[z]     <= '1;
        limit_o[z]    <= '0;
        mode_o[z]     <= ZM_RW;
        key_q[z]      <= '0;
        unlocked_o[z] <= 1'b0;
      end
    end else if (cfg_valid) begin
      for (int z = 0; z < NZONE; z++) begin
        if (int'(cfg_zone) == z) begin
          case (op)
            OP_UNLOCK: unlocked_o[z] <= (cfg_wdata == key_q[z]);
            OP_LOCK:   unlocked_o[z] <= 1'b0;
            OP_BASE:   if (unlocked_o[z]) base_o[z]  <= cfg_wdata;
            OP_LIMIT:  if (unlocked_o[z]) limit_o[z] <= cfg_wdata;
            OP_MODE:   if (unlocked_o[z]) mode_o[z]  <= zone_mode_e'(cfg_wdata[1:0]);
            OP_KEY:    if (unlocked_o[z]) key_q[z]   <= cfg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // shared pin function and unlock error flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_pd_o <= 1'b0;
      pw_err_o <= 1'b0;
    end else if (cfg_valid) begin
      if (op == OP_PINFN) pin_pd_o <= cfg_wdata[0];
      if (op == OP_UNLOCK && zone_ok) pw_err_o <= !key_hit;
    end
  end

endmodule

// File: rtl/zone_match.sv
module zone_match
  import zone_guard_pkg::*;
#(
  parameter int NZONE  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic [ADDR_W-1:0] lba,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] base_i  [NZONE],
  input  logic [ADDR_W-1:0] limit_i [NZONE],
  input  zone_mode_e        mode_i  [NZONE],
  output logic              hit_hidden,
  output logic              hit_ro
);

  localparam int EXT_W = ADDR_W + 1;

  logic [CNT_W-1:0] cnt_eff;
  logic [EXT_W-1:0] first_x;
  logic [EXT_W-1:0] last_x;
  logic [NZONE-1:0] overlap;
  logic [NZONE-1:0] is_hidden;
  logic [NZONE-1:0] is_ro;

  assign cnt_eff = (count == '0) ? CNT_W'(1) : count;
  assign first_x = {1'b0, lba};
  assign last_x  = first_x + EXT_W'(cnt_eff) - EXT_W'(1);

  for (genvar z = 0; z < NZONE; z++) begin : g_zone
    logic [EXT_W-1:0] lo_x;
    logic [EXT_W-1:0] hi_x;
    assign lo_x         = {1'b0, base_i[z]};
    assign hi_x         = {1'b0, limit_i[z]};
    assign overlap[z]   = (lo_x <= hi_x) && (last_x >= lo_x) && (first_x <= hi_x);
    assign is_hidden[z] = (mode_i[z] == ZM_HIDDEN) || (mode_i[z] == ZM_RSVD);
    assign is_ro[z]     = (mode_i[z] == ZM_RO);
  end

  assign hit_hidden = |(overlap & is_hidden);
  assign hit_ro     = |(overlap & is_ro);

endmodule

// File: rtl/access_decide.sv
module access_decide (
  input  logic is_write,
  input  logic hit_hidden,
  input  logic hit_ro,
  input  logic pin_pd,
  input  logic pin_level,
  output logic deny,
  output logic pd_req
);

  logic wp_active;

  assign wp_active = !pin_pd && pin_level;
  assign deny      = hit_hidden || (is_write && (hit_ro || wp_active));
  assign pd_req    = pin_pd && pin_level;

endmodule

// File: rtl/zone_guard.sv
module zone_guard
  import zone_guard_pkg::*;
#(
  parameter int NZONE  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int ZSEL_W = (NZONE > 1) ? $clog2(NZONE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [2:0]        cfg_op,
  input  logic [ZSEL_W-1:0] cfg_zone,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              pw_err,
  input  logic              wppd_in,
  output logic              pd_req,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_lba,
  input  logic [CNT_W-1:0]  req_count,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_allow,
  output logic              rsp_abort
);

  logic [ADDR_W-1:0] base_w  [NZONE];
  logic [ADDR_W-1:0] limit_w [NZONE];
  zone_mode_e        mode_w  [NZONE];
  logic [NZONE-1:0]  unlocked_w;
  logic              pin_pd_w;
  logic              hit_hidden_w;
  logic              hit_ro_w;
  logic              deny_w;
  logic              accept;

  zone_cfg_regs #(.NZONE(NZONE), .ADDR_W(ADDR_W), .ZSEL_W(ZSEL_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_op     (cfg_op),
    .cfg_zone   (cfg_zone),
    .cfg_wdata  (cfg_wdata),
    .base_o     (base_w),
    .limit_o    (limit_w),
    .mode_o     (mode_w),
    .unlocked_o (unlocked_w),
    .pin_pd_o   (pin_pd_w),
    .pw_err_o   (pw_err)
  );

  zone_match #(.NZONE(NZONE), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
    .lba        (req_lba),
    .count      (req_count),
    .base_i     (base_w),
    .limit_i    (limit_w),
    .mode_i     (mode_w),
    .hit_hidden (hit_hidden_w),
    .hit_ro     (hit_ro_w)
  );

  access_decide u_decide (
    .is_write   (req_write),
    .hit_hidden (hit_hidden_w),
    .hit_ro     (hit_ro_w),
    .pin_pd     (pin_pd_w),
    .pin_level  (wppd_in),
    .deny       (deny_w),
    .pd_req     (pd_req)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_abort <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_allow <= !deny_w;
      rsp_abort <= deny_w;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_abort <= 1'b0;
    end
  end

endmodule

// File: rtl/zone_guard_chk.sv
module zone_guard_chk
  import zone_guard_pkg::*;
#(
  parameter int NZONE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             wppd_in,
  input logic             pin_pd_w,
  input logic             hit_hidden_w,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_allow,
  input logic             rsp_abort,
  input logic [NZONE-1:0] unlocked_w,
  input zone_mode_e       mode_w [NZONE]
);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_allow) && $stable(rsp_abort)); // R10

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R10

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_allow ^ rsp_abort)); // R11

  AST_NO_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_allow && !rsp_abort); // R11

  AST_WP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && !pin_pd_w && wppd_in |=> rsp_abort); // R8

  AST_HIDDEN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && hit_hidden_w |=> rsp_abort); // R5

  for (genvar z = 0; z < NZONE; z++) begin : g_lockchk
    AST_LOCKED_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked_w[z] |=> mode_w[z] == $past(mode_w[z])); // R4
  end

endmodule

bind zone_guard zone_guard_chk #(.NZONE(NZONE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .wppd_in      (wppd_in),
  .pin_pd_w     (pin_pd_w),
  .hit_hidden_w (hit_hidden_w),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_allow    (rsp_allow),
  .rsp_abort    (rsp_abort),
  .unlocked_w   (unlocked_w),
  .mode_w       (mode_w)
);

// File: tb/zone_guard_test.sv
module zone_guard_test;

  localparam int NZONE  = 4;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_valid = 1'b0;
  logic [2:0]        cfg_op = '0;
  logic [1:0]        cfg_zone = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic              pw_err;
  logic              wppd_in = 1'b0;
  logic              pd_req;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_lba = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic              rsp_allow;
  logic              rsp_abort;

  zone_guard #(.NZONE(NZONE), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (.*);

  always #10 clk = ~clk;   // 50 MHz

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // bench-side model of the configuration
  longint m_base [NZONE];
  longint m_limit[NZONE];
  int     m_mode [NZONE];
  longint m_key  [NZONE];
  bit     m_unl  [NZONE];
  bit     m_pd;
  bit     m_err;

  bit    exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit model_deny(bit wr, longint lba, longint cnt);
    longint last;
    bit d;
    last = lba + ((cnt == 0) ? 1 : cnt) - 1;
    d = 1'b0;
    for (int z = 0; z < NZONE; z++) begin
      if (m_base[z] <= m_limit[z] && last >= m_base[z] && lba <= m_limit[z]) begin
        if (m_mode[z] >= 2) d = 1'b1;
        if (m_mode[z] == 1 && wr) d = 1'b1;
      end
    end
    if (wr && !m_pd && wppd_in) d = 1'b1;
    return d;
  endfunction

  task automatic cfg(int op, int zone, longint data);
    @(posedge clk); #2;
    cfg_valid = 1'b1; cfg_op = 3'(op); cfg_zone = 2'(zone); cfg_wdata = ADDR_W'(data);
    case (op)
      0: begin m_unl[zone] = (data == m_key[zone]); m_err = (data != m_key[zone]); end
      1: m_unl[zone] = 1'b0;
      2: if (m_unl[zone]) m_base[zone] = data;
      3: if (m_unl[zone]) m_limit[zone] = data;
      4: if (m_unl[zone]) m_mode[zone] = int'(data & 3);
      5: if (m_unl[zone]) m_key[zone] = data;
      6: m_pd = data[0];
      default: ;
    endcase
    @(posedge clk); #2;
    cfg_valid = 1'b0;
  endtask

  // driver: pushes the expected verdict and presents the command
  task automatic send(bit wr, longint lba, longint cnt, string req);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_lba = ADDR_W'(lba); req_count = CNT_W'(cnt);
    exp_q.push_back(!model_deny(wr, lba, cnt));
    tag_q.push_back(req);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  // monitor: compares verdicts as they are taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected verdict", 1, 0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_allow == e, t, "allow", rsp_allow, e);
        check(rsp_abort == !e, "R11", "abort", rsp_abort, !e);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int z = 0; z < NZONE; z++) begin
      m_base[z] = 64'hFFFF_FFFF; m_limit[z] = 0; m_mode[z] = 0; m_key[z] = 0; m_unl[z] = 0;
    end
    m_pd = 0; m_err = 0;
    wppd_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    check(req_ready == 1, "R1", "req_ready", req_ready, 1);
    check(pw_err == 0, "R1", "pw_err", pw_err, 0);
    check(pd_req == 0, "R9", "pd_req in WP function", pd_req, 0);
    wppd_in = 1'b0;
    send(1, 500, 8, "R1");
    send(0, 0, 0, "R1");
    drain();

    // zone 0: read-only 100..199, new key
    cfg(0, 0, 0);
    check(pw_err == 0, "R3", "pw_err after good key", pw_err, 0);
    cfg(2, 0, 100); cfg(3, 0, 199); cfg(4, 0, 1); cfg(5, 0, 'hA5A5); cfg(1, 0, 0);
    // zone 1: hidden 300..399
    cfg(0, 1, 0); cfg(2, 1, 300); cfg(3, 1, 399); cfg(4, 1, 2); cfg(1, 1, 0);
    // zone 2: read-only single sector 1000
    cfg(0, 2, 0); cfg(2, 2, 1000); cfg(3, 2, 1000); cfg(4, 2, 1); cfg(1, 2, 0);

    // R3/R4: wrong key, then attempted change
    cfg(0, 0, 0);
    @(negedge clk);
    check(pw_err == 1, "R3", "pw_err after bad key", pw_err, 1);
    cfg(4, 0, 0); cfg(3, 0, 50);
    send(1, 150, 1, "R4");
    send(1, 199, 1, "R4");
    drain();
    cfg(0, 0, 'hA5A5);
    @(negedge clk);
    check(pw_err == 0, "R3", "pw_err cleared", pw_err, 0);
    cfg(1, 0, 0);

    // R6 read-only
    send(0, 150, 4, "R6");
    send(1, 150, 4, "R6");
    send(1, 200, 10, "R7");
    send(1, 99, 1, "R7");
    send(1, 99, 2, "R7");
    // R5 hidden
    send(0, 350, 1, "R5");
    send(1, 399, 1, "R5");
    send(0, 250, 50, "R7");
    send(0, 250, 51, "R7");
    send(0, 400, 3, "R7");
    // count zero
    send(1, 1000, 0, "R7");
    send(0, 1000, 0, "R7");
    send(1, 1001, 0, "R7");
    drain();

    // R8 write protect
    wppd_in = 1'b1;
    send(1, 5000, 2, "R8");
    send(0, 5000, 2, "R8");
    drain();
    // R9 power-down function
    cfg(6, 0, 1);
    @(negedge clk);
    check(pd_req == 1, "R9", "pd_req", pd_req, 1);
    send(1, 5000, 2, "R9");
    drain();
    wppd_in = 1'b0;
    @(negedge clk);
    check(pd_req == 0, "R9", "pd_req low pin", pd_req, 0);
    cfg(6, 0, 0);

    // R2 reserved code behaves as hidden
    cfg(0, 3, 0); cfg(2, 3, 2000); cfg(3, 3, 2000); cfg(4, 3, 3);
    send(0, 2000, 1, "R2");
    drain();
    // R12 lock then change is ignored
    cfg(1, 3, 0);
    cfg(4, 3, 0);
    send(0, 2000, 1, "R12");
    send(0, 1990, 10, "R2");
    drain();

    // R10 back-pressure
    rsp_ready = 1'b0;
    send(1, 150, 1, "R10");
    repeat (3) @(negedge clk);
    check(rsp_valid == 1, "R10", "verdict held", rsp_valid, 1);
    check(rsp_abort == 1, "R10", "held abort", rsp_abort, 1);
    check(req_ready == 0, "R10", "req_ready stalled", req_ready, 0);
    @(posedge clk); #2;
    rsp_ready = 1'b1;
    drain();
    check(rsp_valid == 0, "R11", "idle valid", rsp_valid, 0);
    check(rsp_allow == 0 && rsp_abort == 0, "R11", "idle verdict", rsp_allow, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule